// File: doc/BRIEF.md
# CAN FD Data-Phase Bit Timer

This block produces the bit timing for the fast data phase of a CAN FD node. A single 32-bit timing register holds four fields, each stored as its length minus one: a clock prescaler, the segment before the sample point, the segment after it, and the resynchronization jump width. The register also holds a delay-compensation enable flag, which is stored and read back but has no other effect. The prescaler divides the module clock into time quanta. Each bit is built from a one-quantum sync segment, then the first segment, then the second segment.

The receive line is recessive at 1 and dominant at 0. The block watches it for recessive-to-dominant transitions. While the bus is idle, such a transition hard-synchronizes the bit timer. During a bit, such a transition resynchronizes it by stretching the first segment or cutting the second segment, limited to the jump width. At the sample point the block pulses a strobe together with the sampled line value. In the same clock it tells the transmitter to present the next bit, because no processing time is allowed after sampling. While the init input is high the timer is held at the start of a sync segment. The timing register can be written only when both the init and change-enable inputs are high.

Top module: `canfd_data_bit_timer`

## Requirements
- R1: After reset the register reads 0x00000A33. Field positions are: prescaler in bits 20:16, first segment in bits 12:8, second segment in bits 7:4, jump width in bits 3:0, compensation enable in bit 23. All other bits always read 0.
- R2: A write in a clock where cfgWrEn is high changes the register only if cfgChangeEn and initMode are both high in that clock. Otherwise the register keeps its value.
- R3: With no bus edges, bitStart pulses repeat every (BRP+1)·(SEG1+SEG2+3) clocks, where BRP, SEG1 and SEG2 are the stored field values.
- R4: sampleStrobe is high in exactly the clock that is (BRP+1)·(SEG1+2)−1 clocks after bitStart. sampleValue equals rxLine in that clock, and txAdvance is high in the same clock.
- R5: bitStart and sampleStrobe are each one clock wide and are never high together.
- R6: While initMode is high neither strobe fires. The first clock after initMode falls is a bitStart.
- R7: A 1-to-0 rxLine transition in clock j while busIdle is high is a hard synchronization. The first segment restarts in clock j+1, so the sample lands at j+(SEG1+1)·(BRP+1) and the next bitStart at j+1+(SEG1+SEG2+2)·(BRP+1).
- R8: A 1-to-0 transition in quantum k (counted from 0) of the first segment, with busIdle low, lengthens that segment by min(k+1, SJW+1) quanta. Both the sample point and the end of the bit move later by that amount.
- R9: A 1-to-0 transition in quantum q of the second segment, with busIdle low, shortens that segment by min(SEG2+1−q, SJW+1) quanta. If the shortened segment would end at or before the current quantum, the next bitStart follows in the very next clock.
- R10: A 1-to-0 transition inside the sync segment, with busIdle low, leaves the timing of that bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the timing register |
| cfgChangeEn | input | 1 | Configuration change enable; one of the two write gates |
| initMode | input | 1 | Initialization mode; holds the timer and is the second write gate |
| cfgWrData | input | 32 | Write data for the timing register |
| cfgRdData | output | 32 | Current timing register value |
| busIdle | input | 1 | High while the bus is idle; selects hard synchronization |
| rxLine | input | 1 | Receive line, 1 = recessive |
| bitStart | output | 1 | One-clock pulse in the first clock of each sync segment |
| sampleStrobe | output | 1 | One-clock pulse at the sample point |
| sampleValue | output | 1 | Sampled rxLine value, valid while sampleStrobe is high |
| txAdvance | output | 1 | High in the clock after which the next transmit bit must be ready |

## Verification
The bench targets edges in the first and last clock of each segment and edges in the middle of a multi-clock quantum. An off-by-one in the phase-error count would move the sample point by a whole quantum. An edge landing exactly in the sample clock must stretch the first segment and not be sampled; a design that samples first would leave the bit short. In the second segment, a cut at the very end of the segment must start the next bit on the next clock. A design that only checks the end on quantum boundaries would hang for a whole extra quantum, or skip the end entirely when the shortened length falls behind the counter. Sync-segment edges, hard synchronization and gated register writes are also driven with random timing fields that obey the jump-width limit.

// File: rtl/canfd_dbt_pkg.sv
package canfd_dbt_pkg;
  localparam int PRESC_W = 5;
  localparam int SEG1_W  = 5;
  localparam int SEG2_W  = 4;
  localparam int SJW_W   = 4;
  // counter wide enough for a stretched first segment
  localparam int CNT_W   = SEG1_W + 2;

  localparam int BRP_LSB  = 16;
  localparam int SEG1_LSB = 8;
  localparam int SEG2_LSB = 4;
  localparam int SJW_LSB  = 0;
  localparam int TDC_BIT  = 23;

  localparam logic [31:0] CFG_RESET = 32'h0000_0A33;
  localparam logic [31:0] CFG_MASK  =
      (32'((1 << PRESC_W) - 1) << BRP_LSB) |
      (32'((1 << SEG1_W) - 1) << SEG1_LSB) |
      (32'((1 << SEG2_W) - 1) << SEG2_LSB) |
      (32'((1 << SJW_W) - 1) << SJW_LSB) |
      (32'd1 << TDC_BIT);

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic loadLens;
    logic extSeg1;
    logic shrinkSeg2;
  } dp_ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic prescEnd;
    logic firstClk;
    logic fallEdge;
    logic resyncUsed;
    logic seg1Last;
    logic seg2Last;
    logic seg2CutNow;
    logic seg2EndShrunk;
  } dp_stat_t;
endpackage

// File: rtl/canfd_dbt_datapath.sv
module canfd_dbt_datapath
  import canfd_dbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgChangeEn,
  input  logic        initMode,
  input  logic [31:0] cfgWrData,
  input  logic        rxLine,
  input  dp_ctl_t     ctl,
  output logic [31:0] cfgRdData,
  output dp_stat_t    stat
);
  logic [31:0]        cfgReg;
  logic [PRESC_W-1:0] brpVal;
  logic [SEG1_W-1:0]  seg1Val;
  logic [SEG2_W-1:0]  seg2Val;
  logic [SJW_W-1:0]   sjwVal;
  logic [CNT_W-1:0]   sjwLen;
  logic [PRESC_W-1:0] prescCnt;
  logic [CNT_W-1:0]   tqCnt;
  logic [CNT_W-1:0]   tqNext;
  logic [CNT_W-1:0]   seg1Len;
  logic [CNT_W-1:0]   seg2Len;
  logic [CNT_W-1:0]   ext1;
  logic [CNT_W-1:0]   remain2;
  logic [CNT_W-1:0]   shrunk2;
  logic               rxPrev;
  logic               resyncUsed;
  logic               prescEnd;

  // gated configuration write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= CFG_RESET;
    end else if (cfgWrEn && cfgChangeEn && initMode) begin
      cfgReg <= cfgWrData & CFG_MASK;
    end
  end

  assign cfgRdData = cfgReg;
  assign brpVal  = cfgReg[BRP_LSB +: PRESC_W];
  assign seg1Val = cfgReg[SEG1_LSB +: SEG1_W];
  assign seg2Val = cfgReg[SEG2_LSB +: SEG2_W];
  assign sjwVal  = cfgReg[SJW_LSB +: SJW_W];
  assign sjwLen  = CNT_W'(sjwVal) + CNT_W'(1);

  assign prescEnd = (prescCnt == brpVal);
  assign tqNext   = tqCnt + CNT_W'(1);
  assign ext1     = (tqNext < sjwLen) ? tqNext : sjwLen;
  assign remain2  = seg2Len - tqCnt;
  assign shrunk2  = seg2Len - sjwLen;

  assign stat.prescEnd      = prescEnd;
  assign stat.firstClk      = (prescCnt == '0) && (tqCnt == '0);
  assign stat.fallEdge      = rxPrev & ~rxLine;
  assign stat.resyncUsed    = resyncUsed;
  assign stat.seg1Last      = prescEnd && (tqCnt == seg1Len - CNT_W'(1));
  assign stat.seg2Last      = prescEnd && (tqCnt == seg2Len - CNT_W'(1));
  assign stat.seg2CutNow    = (remain2 <= sjwLen);
  assign stat.seg2EndShrunk = prescEnd && (tqCnt == shrunk2 - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev <= 1'b1;
    end else begin
      rxPrev <= rxLine;
    end
  end

  // prescaler and quantum counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
      tqCnt    <= '0;
    end else if (ctl.clrCnt) begin
      prescCnt <= '0;
      tqCnt    <= '0;
    end else if (prescEnd) begin
      prescCnt <= '0;
      tqCnt    <= tqNext;
    end else begin
      prescCnt <= prescCnt + PRESC_W'(1);
    end
  end

  // segment lengths for the current bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg1Len    <= CNT_W'(CFG_RESET[SEG1_LSB +: SEG1_W]) + CNT_W'(1);
      seg2Len    <= CNT_W'(CFG_RESET[SEG2_LSB +: SEG2_W]) + CNT_W'(1);
      resyncUsed <= 1'b0;
    end else if (ctl.loadLens) begin
      seg1Len    <= CNT_W'(seg1Val) + CNT_W'(1);
      seg2Len    <= CNT_W'(seg2Val) + CNT_W'(1);
      resyncUsed <= 1'b0;
    end else begin
      if (ctl.extSeg1) begin
        seg1Len <= seg1Len + ext1;
      end
      if (ctl.shrinkSeg2) begin
        seg2Len <= shrunk2;
      end
      if (ctl.extSeg1 || ctl.shrinkSeg2) begin
        resyncUsed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/canfd_dbt_control.sv
module canfd_dbt_control
  import canfd_dbt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     initMode,
  input  logic     busIdle,
  input  dp_stat_t stat,
  output dp_ctl_t  ctl,
  output logic     bitStart,
  output logic     sampleStrobe
);
  phase_e phase;
  phase_e phaseNxt;
  logic   resyncNow;

  assign resyncNow = stat.fallEdge && !stat.resyncUsed;

  always_comb begin
    phaseNxt     = phase;
    ctl          = '0;
    bitStart     = 1'b0;
    sampleStrobe = 1'b0;
    if (initMode) begin
      phaseNxt     = PH_SYNC;
      ctl.clrCnt   = 1'b1;
      ctl.loadLens = 1'b1;
    end else if (busIdle && stat.fallEdge) begin
      // hard sync: this clock is the sync segment
      phaseNxt     = PH_SEG1;
      ctl.clrCnt   = 1'b1;
      ctl.loadLens = 1'b1;
    end else begin
      unique case (phase)
        PH_SYNC: begin
          ctl.loadLens = 1'b1;
          bitStart     = stat.firstClk;
          if (stat.prescEnd) begin
            phaseNxt   = PH_SEG1;
            ctl.clrCnt = 1'b1;
          end
        end
        PH_SEG1: begin
          if (resyncNow) begin
            ctl.extSeg1 = 1'b1;
          end else if (stat.seg1Last) begin
            sampleStrobe = 1'b1;
            phaseNxt     = PH_SEG2;
            ctl.clrCnt   = 1'b1;
          end
        end
        PH_SEG2: begin
          if (resyncNow && (stat.seg2CutNow || stat.seg2EndShrunk)) begin
            phaseNxt   = PH_SYNC;
            ctl.clrCnt = 1'b1;
          end else if (resyncNow) begin
            ctl.shrinkSeg2 = 1'b1;
          end else if (stat.seg2Last) begin
            phaseNxt   = PH_SYNC;
            ctl.clrCnt = 1'b1;
          end
        end
        default: begin
          phaseNxt   = PH_SYNC;
          ctl.clrCnt = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_SYNC;
    end else begin
      phase <= phaseNxt;
    end
  end
endmodule

// File: rtl/canfd_data_bit_timer.sv
module canfd_data_bit_timer
  import canfd_dbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgChangeEn,
  input  logic        initMode,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        busIdle,
  input  logic        rxLine,
  output logic        bitStart,
  output logic        sampleStrobe,
  output logic        sampleValue,
  output logic        txAdvance
);
  dp_ctl_t  ctl;
  dp_stat_t stat;

  canfd_dbt_datapath uDp (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgChangeEn (cfgChangeEn),
    .initMode    (initMode),
    .cfgWrData   (cfgWrData),
    .rxLine      (rxLine),
    .ctl         (ctl),
    .cfgRdData   (cfgRdData),
    .stat        (stat)
  );

  canfd_dbt_control uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .initMode     (initMode),
    .busIdle      (busIdle),
    .stat         (stat),
    .ctl          (ctl),
    .bitStart     (bitStart),
    .sampleStrobe (sampleStrobe)
  );

  assign sampleValue = sampleStrobe & rxLine;
  // zero processing time: next tx bit is due at the following edge
  assign txAdvance   = sampleStrobe;
endmodule

// File: rtl/canfd_data_bit_timer_chk.sv
module canfd_data_bit_timer_chk
  import canfd_dbt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic        cfgChangeEn,
  input logic        initMode,
  input logic [31:0] cfgWrData,
  input logic [31:0] cfgRdData,
  input logic        busIdle,
  input logic        rxLine,
  input logic        bitStart,
  input logic        sampleStrobe,
  input logic        sampleValue,
  input logic        txAdvance
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & ~CFG_MASK) == 32'd0);

  // R2
  cfg_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && cfgChangeEn && initMode) |=> $stable(cfgRdData));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bitStart && sampleStrobe));

  // R5
  start_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitStart |=> !bitStart);

  // R5
  sample_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);

  // R6
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    initMode |-> (!bitStart && !sampleStrobe));

  // R6
  release_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(initMode) && !busIdle) |-> bitStart);
endmodule

bind canfd_data_bit_timer canfd_data_bit_timer_chk uChk (.*);

// File: tb/tb_canfd_data_bit_timer.sv
module tb_canfd_data_bit_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgChangeEn = 1'b0;
  logic        initMode = 1'b1;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        busIdle = 1'b0;
  logic        rxLine = 1'b1;
  logic        bitStart, sampleStrobe, sampleValue, txAdvance;

  localparam int M_NONE = 0, M_SYNC = 1, M_SEG1 = 2, M_SEG2 = 3, M_HARD = 4;

  always #4 clk = ~clk;

  canfd_data_bit_timer dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgChangeEn(cfgChangeEn),
    .initMode(initMode), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .busIdle(busIdle), .rxLine(rxLine), .bitStart(bitStart),
    .sampleStrobe(sampleStrobe), .sampleValue(sampleValue), .txAdvance(txAdvance)
  );

  int nChecks = 0;
  int nFail = 0;
  int P, t1, t2, sjw;

  function automatic void check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic string reqOf(int mode);
    case (mode)
      M_SYNC: return "R10 sync-segment edge";
      M_SEG1: return "R8 first-segment resync";
      M_SEG2: return "R9 second-segment resync";
      M_HARD: return "R7 hard sync";
      default: return "R3 nominal bit";
    endcase
  endfunction

  function automatic int expSample(int mode, int j);
    int ext;
    case (mode)
      M_SEG1: begin
        ext = imin((j - P) / P + 1, sjw + 1);
        return P * (t1 + 2 + ext) - 1;
      end
      M_HARD: return j + (t1 + 1) * P;
      default: return P * (t1 + 2) - 1;
    endcase
  endfunction

  function automatic int expNext(int mode, int j);
    int ext, q, e;
    case (mode)
      M_SEG1: begin
        ext = imin((j - P) / P + 1, sjw + 1);
        return P * (t1 + t2 + 3 + ext);
      end
      M_SEG2: begin
        q = (j - P * (t1 + 2)) / P;
        e = t2 + 1 - q;
        if (e <= sjw + 1) return j + 1;
        return P * (t1 + 2) + (t2 + 1 - (sjw + 1)) * P;
      end
      M_HARD: return j + 1 + (t1 + t2 + 2) * P;
      default: return P * (t1 + t2 + 3);
    endcase
  endfunction

  task automatic writeCfg(input logic [31:0] d, input logic ce, input logic ini);
    @(negedge clk);
    cfgWrData = d; cfgWrEn = 1'b1; cfgChangeEn = ce; initMode = ini;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgChangeEn = 1'b0;
  endtask

  task automatic waitBitStart();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); #1;
      if (bitStart) break;
    end
  endtask

  task automatic setTiming(input int brp, input int a, input int b, input int s);
    logic [31:0] d;
    d = (32'(brp) << 16) | (32'(a) << 8) | (32'(b) << 4) | 32'(s);
    writeCfg(d, 1'b1, 1'b1);
    P = brp + 1; t1 = a; t2 = b; sjw = s;
    check(cfgRdData == d, "R2 accepted write", cfgRdData, d);
    @(negedge clk);
    initMode = 1'b0;
    #1;
    check(bitStart == 1'b1, "R6 bitStart after init release", bitStart, 1);
  endtask

  task automatic runBit(input int mode, input int j);
    int sT, nT;
    logic sV, txA;
    sT = -1; nT = -1; sV = 1'b0; txA = 1'b0;
    waitBitStart();
    if (j == 0 && mode != M_NONE) rxLine = 1'b0;
    for (int t = 1; t < 700; t++) begin
      @(negedge clk);
      if (t == j) begin
        rxLine = 1'b0;
        if (mode == M_HARD) busIdle = 1'b1;
      end
      #1;
      if (sampleStrobe && sT < 0) begin sT = t; sV = sampleValue; txA = txAdvance; end
      if (bitStart) begin nT = t; break; end
    end
    rxLine = 1'b1; busIdle = 1'b0;
    check(sT == expSample(mode, j), {reqOf(mode), " / R4 sample clock"}, sT, expSample(mode, j));
    check(nT == expNext(mode, j), reqOf(mode), nT, expNext(mode, j));
    check(sV == ((mode == M_NONE || mode == M_SEG2) ? 1'b1 : 1'b0),
          "R4 sampled value", sV, (mode == M_NONE || mode == M_SEG2) ? 1 : 0);
    check(txA == 1'b1, "R4 txAdvance at sample", txA, 1);
  endtask

  task automatic runSet(input int nRand);
    runBit(M_NONE, -1);
    runBit(M_SEG1, P);
    runBit(M_SEG1, P * (t1 + 2) - 1);
    runBit(M_SEG2, P * (t1 + 2));
    runBit(M_SEG2, P * (t1 + t2 + 3) - 1);
    runBit(M_SYNC, P - 1);
    runBit(M_HARD, 1);
    runBit(M_HARD, P * (t1 + 2) - 1);
    for (int i = 0; i < nRand; i++) begin
      int m, j;
      m = $urandom_range(4, 0);
      case (m)
        M_SYNC: j = $urandom_range(P - 1, 0);
        M_SEG1: j = $urandom_range(P * (t1 + 2) - 1, P);
        M_SEG2: j = $urandom_range(P * (t1 + t2 + 3) - 1, P * (t1 + 2));
        M_HARD: j = $urandom_range(P * (t1 + 2) - 1, 1);
        default: j = -1;
      endcase
      runBit(m, j);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic quietBad;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(cfgRdData == 32'h0000_0A33, "R1 reset value", cfgRdData, 32'h0000_0A33);
    check(bitStart == 1'b0 && sampleStrobe == 1'b0, "R6 no strobe in init", bitStart, 0);

    writeCfg(32'hFFFF_FFFF, 1'b0, 1'b1);
    #1;
    check(cfgRdData == 32'h0000_0A33, "R2 write without change enable", cfgRdData, 32'h0000_0A33);
    writeCfg(32'hFFFF_FFFF, 1'b1, 1'b0);
    #1;
    check(cfgRdData == 32'h0000_0A33, "R2 write without init", cfgRdData, 32'h0000_0A33);
    writeCfg(32'hFFFF_FFFF, 1'b1, 1'b1);
    #1;
    check(cfgRdData == 32'h009F_1FFF, "R1 reserved bits read zero", cfgRdData, 32'h009F_1FFF);

    quietBad = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (bitStart || sampleStrobe) quietBad = 1'b1;
    end
    check(!quietBad, "R6 quiet while held", quietBad, 0);

    setTiming(0, 10, 3, 2);
    runSet(4);
    setTiming(3, 0, 1, 0);
    runSet(4);
    setTiming(2, 31, 15, 14);
    runSet(3);
    for (int c = 0; c < 5; c++) begin
      int b, a, s2, s;
      b  = $urandom_range(3, 0);
      a  = $urandom_range(31, 0);
      s2 = $urandom_range(15, 1);
      s  = $urandom_range(s2 - 1, 0);
      initMode = 1'b1;
      setTiming(b, a, s2, s);
      runSet(6);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule